// File: doc/BRIEF.md
# Instruction Byte-Stream Length Decoder

This block takes a stream of instruction bytes for a simplified 32-bit variable-length instruction set, one byte per cycle, and splits it into instructions. Each instruction has these parts in this order: zero or more prefix bytes, a one-byte opcode, an optional ModRM byte, an optional SIB byte, an optional displacement and an optional immediate. The length is not fixed. It is worked out while the bytes arrive, from the prefixes seen, a small built-in opcode attribute table, the ModRM mode and r/m fields and the SIB base field.

When the last byte of an instruction has been taken, the block presents a record on its output. The record holds the prefix flags, the opcode, the ModRM and SIB bytes with their presence bits, the assembled displacement and immediate, and the byte count. The record stays until the consumer takes it, and no input byte is accepted while a record is waiting. An instruction that reaches the length limit before it is complete is closed with a fault record. Parsing starts again with the next byte.

Top module: `insn_len_decoder`

## Requirements
- R1: A byte is consumed in each cycle where `in_valid` and `in_ready` are both high. The record for an instruction is presented (`out_valid` high) in the cycle after its final byte is consumed, and `in_ready` stays low while `out_valid` is high.
- R2: While `out_valid` is high and `out_ready` is low, every record output holds its value. In the cycle after `out_valid` and `out_ready` are both high, `out_valid` is low and `in_ready` is high.
- R3: The prefix bytes each set one bit of `out_prefix` and are consumed before the opcode: 0x26/0x2E/0x36/0x3E/0x64/0x65 set bit 0 (segment), 0x66 sets bit 1 (operand size), 0x67 sets bit 2 (address size), 0xF0 sets bit 3 (lock), 0xF3 sets bit 4 (repeat), 0xF2 sets bit 5 (repeat-not-equal).
- R4: The opcode table:
  - 0x00–0x03, 0x88–0x8B: ModRM, no immediate.
  - 0x04, 0x6A: 1-byte immediate.
  - 0x05, 0x68, 0xB8–0xBF: operand-sized immediate.
  - 0x80, 0x83, 0xC6: ModRM plus 1-byte immediate.
  - 0x81, 0xC7: ModRM plus operand-sized immediate.
  - 0xC2: 2-byte immediate.
  - 0xE8, 0xE9: 4-byte relative displacement, no ModRM.
  - 0xEB: 1-byte relative displacement, no ModRM.
  - Every other opcode (for example 0x50–0x5F, 0x90, 0xC3): one byte only.
- R5: ModRM is mod[7:6], reg[5:3], r/m[2:0]. mod=1 adds a 1-byte displacement, mod=2 adds a 4-byte displacement, and mod=0 and mod=3 add none, except for the cases in R7.
- R6: A SIB byte follows ModRM exactly when mod≠3 and r/m=4. `out_has_sib` reports it and `out_sib` holds it.
- R7: With mod=0 and r/m=5, a 4-byte displacement follows. With mod=0, a SIB byte present and SIB base (bits 2:0) equal to 5, a 4-byte displacement follows. With mod=1 or mod=2, SIB base 5 does not change the displacement size.
- R8: Displacement and immediate bytes arrive least-significant first. A 1-byte displacement (from ModRM or from a 1-byte relative opcode) is sign-extended to 32 bits. Immediates are zero-extended. Fields that are absent read zero.
- R9: An operand-sized immediate is 4 bytes. It is 2 bytes when the operand-size prefix was seen.
- R10: `out_len` equals the number of bytes consumed for the instruction, prefixes included.
- R11: The length limit is `MAX_LEN` (default 15). If the byte that brings the count to `MAX_LEN` does not complete the instruction, a record with `out_fault`=1 and `out_len`=`MAX_LEN` is emitted at once. The next byte starts a new instruction. An instruction of exactly `MAX_LEN` bytes is not a fault.
- R12: After reset `out_valid` is low and `in_ready` is high.
- R13: The address-size prefix is only recorded. It does not change how ModRM or SIB are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can take a byte |
| out_valid | output | 1 | Record is presented |
| out_ready | input | 1 | Consumer takes the record |
| out_prefix | output | 6 | Prefix flags (R3 bit order) |
| out_opcode | output | 8 | Opcode byte |
| out_has_modrm | output | 1 | ModRM byte present |
| out_modrm | output | 8 | ModRM byte (zero if absent) |
| out_has_sib | output | 1 | SIB byte present |
| out_sib | output | 8 | SIB byte (zero if absent) |
| out_disp | output | 32 | Displacement, sign-extended if 1 byte |
| out_imm | output | 32 | Immediate, zero-extended |
| out_len | output | 4 | Instruction length in bytes |
| out_fault | output | 1 | Length limit exceeded |

## Verification
Each byte is taken at the rising edge where `in_valid` and `in_ready` are both high. The record is registered on that same edge, so it is due one cycle after the final byte. The bench drops `in_valid` at the following falling edge and checks `out_valid` and `in_ready` right there. It then holds `out_ready` low for one more cycle to confirm the record has not moved, and only then accepts it. One cycle after acceptance, the bench checks that `out_valid` has cleared and that the block is ready again.

// File: rtl/ild_pkg.sv
package ild_pkg;

    localparam int PFX_W    = 6;
    localparam int PFX_SEG  = 0;
    localparam int PFX_OPSZ = 1;
    localparam int PFX_ADSZ = 2;
    localparam int PFX_LOCK = 3;
    localparam int PFX_REP  = 4;
    localparam int PFX_REPN = 5;

    typedef enum logic [2:0] {
        ST_HEAD  = 3'd0,
        ST_MODRM = 3'd1,
        ST_SIB   = 3'd2,
        ST_DISP  = 3'd3,
        ST_IMM   = 3'd4,
        ST_DONE  = 3'd5
    } ild_state_e;

    typedef enum logic [1:0] {
        IMM_NONE = 2'd0,
        IMM_B1   = 2'd1,
        IMM_B2   = 2'd2,
        IMM_OPSZ = 2'd3
    } imm_kind_e;

    typedef enum logic [1:0] {
        REL_NONE = 2'd0,
        REL_B1   = 2'd1,
        REL_B4   = 2'd2
    } rel_kind_e;

    typedef struct packed {
        logic      has_modrm;
        imm_kind_e imm;
        rel_kind_e rel;
    } opc_attr_t;

endpackage

// File: rtl/ild_prefix_class.sv
module ild_prefix_class
    import ild_pkg::*;
(
    input  logic [7:0]       byte_i,
    output logic             is_pfx_o,
    output logic [PFX_W-1:0] flag_o
);
    always_comb begin
        flag_o = '0;
        unique case (byte_i)
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: flag_o[PFX_SEG] = 1'b1;
            8'h66: flag_o[PFX_OPSZ] = 1'b1;
            8'h67: flag_o[PFX_ADSZ] = 1'b1;
            8'hF0: flag_o[PFX_LOCK] = 1'b1;
            8'hF3: flag_o[PFX_REP]  = 1'b1;
            8'hF2: flag_o[PFX_REPN] = 1'b1;
            default: flag_o = '0;
        endcase
        is_pfx_o = |flag_o;
    end
endmodule

// File: rtl/ild_opc_attr.sv
module ild_opc_attr
    import ild_pkg::*;
(
    input  logic [7:0] opc_i,
    output opc_attr_t  attr_o
);
    always_comb begin
        attr_o = '{has_modrm: 1'b0, imm: IMM_NONE, rel: REL_NONE};
        if (opc_i <= 8'h03 || (opc_i >= 8'h88 && opc_i <= 8'h8B)) begin
            attr_o.has_modrm = 1'b1;
        end else if (opc_i >= 8'hB8 && opc_i <= 8'hBF) begin
            attr_o.imm = IMM_OPSZ;
        end else begin
            unique case (opc_i)
                8'h04, 8'h6A: attr_o.imm = IMM_B1;
                8'h05, 8'h68: attr_o.imm = IMM_OPSZ;
                8'h80, 8'h83, 8'hC6: begin
                    attr_o.has_modrm = 1'b1;
                    attr_o.imm       = IMM_B1;
                end
                8'h81, 8'hC7: begin
                    attr_o.has_modrm = 1'b1;
                    attr_o.imm       = IMM_OPSZ;
                end
                8'hC2: attr_o.imm = IMM_B2;
                8'hE8, 8'hE9: attr_o.rel = REL_B4;
                8'hEB: attr_o.rel = REL_B1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
    import ild_pkg::*;
#(
    parameter int MAX_LEN = 15,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PFX_W-1:0] out_prefix,
    output logic [7:0]       out_opcode,
    output logic             out_has_modrm,
    output logic [7:0]       out_modrm,
    output logic             out_has_sib,
    output logic [7:0]       out_sib,
    output logic [31:0]      out_disp,
    output logic [31:0]      out_imm,
    output logic [LEN_W-1:0] out_len,
    output logic             out_fault
);
    typedef struct packed {
        ild_state_e       st;
        logic [PFX_W-1:0] pfx;
        logic [7:0]       opc;
        logic             hm;
        logic [7:0]       modrm;
        logic             hs;
        logic [7:0]       sib;
        logic [31:0]      disp;
        logic [31:0]      imm;
        logic [2:0]       dleft;
        logic [2:0]       ileft;
        logic [1:0]       idx;
        logic             d8;
        logic [LEN_W-1:0] len;
        logic             fault;
    } regs_t;

    regs_t r_d, r_q;

    logic             pfx_hit;
    logic [PFX_W-1:0] pfx_flag;
    opc_attr_t        attr;

    ild_prefix_class u_pfx (.byte_i(in_byte), .is_pfx_o(pfx_hit), .flag_o(pfx_flag));
    ild_opc_attr     u_attr (.opc_i(in_byte), .attr_o(attr));

    function automatic ild_state_e after_fields(logic [2:0] dl, logic [2:0] il);
        if (dl != '0)      return ST_DISP;
        else if (il != '0) return ST_IMM;
        else               return ST_DONE;
    endfunction

    logic             take;
    logic [LEN_W-1:0] len_n;
    ild_state_e       target;

    always_comb begin
        r_d    = r_q;
        take   = in_valid && in_ready;
        len_n  = r_q.len + 1'b1;
        target = r_q.st;

        unique case (r_q.st)
            ST_HEAD: begin
                if (pfx_hit) begin
                    r_d.pfx = r_q.pfx | pfx_flag;
                    target  = ST_HEAD;
                end else begin
                    r_d.opc = in_byte;
                    r_d.hm  = attr.has_modrm;
                    unique case (attr.imm)
                        IMM_B1:   r_d.ileft = 3'd1;
                        IMM_B2:   r_d.ileft = 3'd2;
                        IMM_OPSZ: r_d.ileft = r_q.pfx[PFX_OPSZ] ? 3'd2 : 3'd4;
                        default:  r_d.ileft = 3'd0;
                    endcase
                    unique case (attr.rel)
                        REL_B1:  r_d.dleft = 3'd1;
                        REL_B4:  r_d.dleft = 3'd4;
                        default: r_d.dleft = 3'd0;
                    endcase
                    r_d.d8 = (attr.rel == REL_B1);
                    target = attr.has_modrm ? ST_MODRM : after_fields(r_d.dleft, r_d.ileft);
                end
            end
            ST_MODRM: begin
                r_d.modrm = in_byte;
                unique case (in_byte[7:6])
                    2'd1:    r_d.dleft = 3'd1;
                    2'd2:    r_d.dleft = 3'd4;
                    2'd0:    r_d.dleft = (in_byte[2:0] == 3'd5) ? 3'd4 : 3'd0;
                    default: r_d.dleft = 3'd0;
                endcase
                r_d.d8 = (in_byte[7:6] == 2'd1);
                if (in_byte[7:6] != 2'd3 && in_byte[2:0] == 3'd4) begin
                    r_d.hs = 1'b1;
                    target = ST_SIB;
                end else begin
                    target = after_fields(r_d.dleft, r_q.ileft);
                end
            end
            ST_SIB: begin
                r_d.sib = in_byte;
                if (r_q.modrm[7:6] == 2'd0 && in_byte[2:0] == 3'd5) r_d.dleft = 3'd4;
                target = after_fields(r_d.dleft, r_q.ileft);
            end
            ST_DISP: begin
                r_d.disp[{r_q.idx, 3'b000} +: 8] = in_byte;
                r_d.dleft = r_q.dleft - 1'b1;
                if (r_q.dleft == 3'd1) begin
                    if (r_q.d8) r_d.disp[31:8] = {24{in_byte[7]}};
                    target = after_fields(3'd0, r_q.ileft);
                end else begin
                    target = ST_DISP;
                end
            end
            ST_IMM: begin
                r_d.imm[{r_q.idx, 3'b000} +: 8] = in_byte;
                r_d.ileft = r_q.ileft - 1'b1;
                target    = (r_q.ileft == 3'd1) ? ST_DONE : ST_IMM;
            end
            default: target = ST_DONE;
        endcase

        if (r_q.st == ST_DONE) begin
            r_d = r_q;
            if (out_ready) r_d = '0;
        end else if (!take) begin
            r_d = r_q;
        end else begin
            r_d.len = len_n;
            r_d.idx = (target == r_q.st) ? r_q.idx + 1'b1 : 2'd0;
            if (target != ST_DONE && len_n == LEN_W'(MAX_LEN)) begin
                r_d.st    = ST_DONE;
                r_d.fault = 1'b1;
            end else begin
                r_d.st = target;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_ready      = (r_q.st != ST_DONE);
    assign out_valid     = (r_q.st == ST_DONE);
    assign out_prefix    = r_q.pfx;
    assign out_opcode    = r_q.opc;
    assign out_has_modrm = r_q.hm;
    assign out_modrm     = r_q.modrm;
    assign out_has_sib   = r_q.hs;
    assign out_sib       = r_q.sib;
    assign out_disp      = r_q.disp;
    assign out_imm       = r_q.imm;
    assign out_len       = r_q.len;
    assign out_fault     = r_q.fault;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_disp)
            && $stable(out_imm) && $stable(out_prefix) && $stable(out_opcode));

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready);

    p_len_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len != '0 && out_len <= LEN_W'(MAX_LEN));

    p_fault_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fault |-> out_len == LEN_W'(MAX_LEN));

    p_sib_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fault && out_has_sib |->
            out_has_modrm && out_modrm[7:6] != 2'd3 && out_modrm[2:0] == 3'd4);

    p_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fault && out_has_modrm && out_modrm[7:6] == 2'd1 |->
            out_disp[31:8] == {24{out_disp[7]}});

endmodule

// File: tb/insn_len_decoder_test.sv
`timescale 1ns/1ps
module insn_len_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [5:0]  out_prefix;
    logic [7:0]  out_opcode;
    logic        out_has_modrm;
    logic [7:0]  out_modrm;
    logic        out_has_sib;
    logic [7:0]  out_sib;
    logic [31:0] out_disp;
    logic [31:0] out_imm;
    logic [3:0]  out_len;
    logic        out_fault;

    int total = 0;
    int fails = 0;
    logic [7:0] bq [0:15];
    int nb = 0;

    always #2.5 clk = ~clk;

    insn_len_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_prefix(out_prefix), .out_opcode(out_opcode),
        .out_has_modrm(out_has_modrm), .out_modrm(out_modrm),
        .out_has_sib(out_has_sib), .out_sib(out_sib), .out_disp(out_disp),
        .out_imm(out_imm), .out_len(out_len), .out_fault(out_fault)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(logic [7:0] b);
        bq[nb] = b;
        nb++;
    endtask

    // Feeds the queued bytes and checks the record appears one cycle after the last byte (R1).
    task automatic feed();
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = bq[i];
            @(posedge clk);
        end
        nb = 0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 out_valid after last byte", 32'(out_valid), 32'd1);
        chk("R1 in_ready low while pending", 32'(in_ready), 32'd0);
    endtask

    task automatic expect_rec(string tag, logic [5:0] pfx, logic [7:0] opc, logic hm,
                              logic [7:0] mrm, logic hs, logic [7:0] sib,
                              logic [31:0] disp, logic [31:0] imm, int len, logic flt);
        chk({tag, " prefix"}, 32'(out_prefix), 32'(pfx));
        if (!flt) begin
            chk({tag, " opcode"}, 32'(out_opcode), 32'(opc));
            chk({tag, " has_modrm"}, 32'(out_has_modrm), 32'(hm));
            chk({tag, " modrm"}, 32'(out_modrm), 32'(mrm));
            chk({tag, " has_sib"}, 32'(out_has_sib), 32'(hs));
            chk({tag, " sib"}, 32'(out_sib), 32'(sib));
            chk({tag, " disp"}, out_disp, disp);
            chk({tag, " imm"}, out_imm, imm);
        end
        chk({tag, " R10 len"}, 32'(out_len), 32'(len));
        chk({tag, " R11 fault"}, 32'(out_fault), 32'(flt));
        @(negedge clk);
        chk("R2 record held", {out_valid, out_len, out_disp[26:0]},
            {1'b1, 4'(len), disp[26:0] & {27{!flt}} | out_disp[26:0] & {27{flt}}});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R2 released out_valid", 32'(out_valid), 32'd0);
        chk("R2 released in_ready", 32'(in_ready), 32'd1);
    endtask

    task automatic t_reset();
        chk("R12 reset out_valid", 32'(out_valid), 32'd0);
        chk("R12 reset in_ready", 32'(in_ready), 32'd1);
    endtask

    task automatic t_single_byte();
        put(8'h53); feed();
        expect_rec("R4 push", 6'h00, 8'h53, 0, 8'h00, 0, 8'h00, 0, 0, 1, 0);
        put(8'hC3); feed();
        expect_rec("R4 ret", 6'h00, 8'hC3, 0, 8'h00, 0, 8'h00, 0, 0, 1, 0);
    endtask

    task automatic t_modrm_modes();
        put(8'h03); put(8'h11); feed();
        expect_rec("R5 mod0", 0, 8'h03, 1, 8'h11, 0, 0, 0, 0, 2, 0);
        put(8'h03); put(8'h4A); put(8'h04); feed();
        expect_rec("R5 mod1", 0, 8'h03, 1, 8'h4A, 0, 0, 32'h4, 0, 3, 0);
        put(8'h03); put(8'h4A); put(8'hF0); feed();
        expect_rec("R8 disp8 sext", 0, 8'h03, 1, 8'h4A, 0, 0, 32'hFFFF_FFF0, 0, 3, 0);
        put(8'h03); put(8'h8A); put(8'h78); put(8'h56); put(8'h34); put(8'h12); feed();
        expect_rec("R5 R8 mod2", 0, 8'h03, 1, 8'h8A, 0, 0, 32'h1234_5678, 0, 6, 0);
        put(8'h03); put(8'hCA); feed();
        expect_rec("R5 mod3", 0, 8'h03, 1, 8'hCA, 0, 0, 0, 0, 2, 0);
        put(8'h8B); put(8'hCC); feed();
        expect_rec("R6 mod3 rm4 no sib", 0, 8'h8B, 1, 8'hCC, 0, 0, 0, 0, 2, 0);
    endtask

    task automatic t_sib();
        put(8'h8B); put(8'h04); put(8'h8B); feed();
        expect_rec("R6 sib mod0", 0, 8'h8B, 1, 8'h04, 1, 8'h8B, 0, 0, 3, 0);
        put(8'h8B); put(8'h44); put(8'h8B); put(8'h10); feed();
        expect_rec("R6 sib mod1", 0, 8'h8B, 1, 8'h44, 1, 8'h8B, 32'h10, 0, 4, 0);
    endtask

    task automatic t_no_base();
        put(8'h8B); put(8'h05); put(8'hEF); put(8'hBE); put(8'hAD); put(8'hDE); feed();
        expect_rec("R7 mod0 rm5", 0, 8'h8B, 1, 8'h05, 0, 0, 32'hDEAD_BEEF, 0, 6, 0);
        put(8'h8B); put(8'h04); put(8'h8D);
        put(8'h44); put(8'h33); put(8'h22); put(8'h11); feed();
        expect_rec("R7 sib base5 mod0", 0, 8'h8B, 1, 8'h04, 1, 8'h8D, 32'h1122_3344, 0, 7, 0);
        put(8'h8B); put(8'h44); put(8'h8D); put(8'h08); feed();
        expect_rec("R7 sib base5 mod1", 0, 8'h8B, 1, 8'h44, 1, 8'h8D, 32'h8, 0, 4, 0);
    endtask

    task automatic t_immediates();
        put(8'h05); put(8'h78); put(8'h56); put(8'h34); put(8'h12); feed();
        expect_rec("R9 imm32", 0, 8'h05, 0, 0, 0, 0, 0, 32'h1234_5678, 5, 0);
        put(8'h66); put(8'h05); put(8'h34); put(8'h12); feed();
        expect_rec("R9 R3 imm16 opsz", 6'h02, 8'h05, 0, 0, 0, 0, 0, 32'h1234, 4, 0);
        put(8'h04); put(8'hFF); feed();
        expect_rec("R8 imm8 zext", 0, 8'h04, 0, 0, 0, 0, 0, 32'hFF, 2, 0);
        put(8'hC2); put(8'h08); put(8'h00); feed();
        expect_rec("R4 imm16 fixed", 0, 8'hC2, 0, 0, 0, 0, 0, 32'h8, 3, 0);
        put(8'h81); put(8'hC1); put(8'h01); put(8'h02); put(8'h03); put(8'h04); feed();
        expect_rec("R4 modrm imm32", 0, 8'h81, 1, 8'hC1, 0, 0, 0, 32'h0403_0201, 6, 0);
        put(8'hC7); put(8'h05); put(8'h00); put(8'h10); put(8'h00); put(8'h00);
        put(8'hAA); put(8'hBB); put(8'hCC); put(8'hDD); feed();
        expect_rec("R4 R7 disp32 imm32", 0, 8'hC7, 1, 8'h05, 0, 0, 32'h1000, 32'hDDCC_BBAA, 10, 0);
    endtask

    task automatic t_relative();
        put(8'hE9); put(8'h10); put(8'h20); put(8'h30); put(8'h40); feed();
        expect_rec("R4 rel32", 0, 8'hE9, 0, 0, 0, 0, 32'h4030_2010, 0, 5, 0);
        put(8'hEB); put(8'hFE); feed();
        expect_rec("R8 rel8 sext", 0, 8'hEB, 0, 0, 0, 0, 32'hFFFF_FFFE, 0, 2, 0);
    endtask

    task automatic t_prefixes();
        put(8'hF0); put(8'hF3); put(8'hF2); put(8'h2E); put(8'h67); put(8'h90); feed();
        expect_rec("R3 all flags", 6'h3D, 8'h90, 0, 0, 0, 0, 0, 0, 6, 0);
        put(8'h67); put(8'h8B); put(8'h05);
        put(8'h01); put(8'h00); put(8'h00); put(8'h00); feed();
        expect_rec("R13 adsz no effect", 6'h04, 8'h8B, 1, 8'h05, 0, 0, 32'h1, 0, 7, 0);
    endtask

    task automatic t_length_limit();
        for (int i = 0; i < 10; i++) put(8'h26);
        put(8'h05); put(8'h01); put(8'h02); put(8'h03); put(8'h04); feed();
        expect_rec("R11 exactly 15", 6'h01, 8'h05, 0, 0, 0, 0, 0, 32'h0403_0201, 15, 0);
        for (int i = 0; i < 15; i++) put(8'h26);
        feed();
        expect_rec("R11 prefix overrun", 6'h01, 0, 0, 0, 0, 0, 0, 0, 15, 1);
        put(8'h90); feed();
        expect_rec("R11 resync", 0, 8'h90, 0, 0, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 11; i++) put(8'h3E);
        put(8'h05); put(8'h01); put(8'h02); put(8'h03); feed();
        expect_rec("R11 imm overrun", 6'h01, 0, 0, 0, 0, 0, 0, 0, 15, 1);
        put(8'h53); feed();
        expect_rec("R11 resync after imm", 0, 8'h53, 0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_byte();
        t_modrm_modes();
        t_sib();
        t_no_base();
        t_immediates();
        t_relative();
        t_prefixes();
        t_length_limit();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule